// File: doc/BRIEF.md
# SD Host Block-Data DMA Engine

This engine is the bus master inside an SD host controller that moves block data between the host's data buffer and system memory. It runs one channel at a time over one contiguous buffer, in either direction. Software programs a transfer mode, a 64-bit start address and a length. It then sets a start bit, and the engine runs the whole segment one beat at a time without further help.

On the memory side the engine issues single-beat requests and holds each one until the memory acknowledges it. On the buffer side it drives an outbound valid/ready stream toward the card for memory-to-card transfers. For card-to-memory transfers it accepts an inbound valid/ready stream. A one-cycle completion pulse marks the end of a segment. Software can abort a transfer by taking the active channel's reset bit low.

Top module: `sdh_dma_top`

## Requirements
- R1: After reset the engine is idle (busy and done low), the mode word and both address words read zero, the control word reads zero, and the channel-reset word reads 0x300 (both run bits set).
- R2: Register offsets are mode 0x00, control 0x04, channel reset 0x08, address low 0x0C and address high 0x10. In the mode word, bits [17:16] are the direction field, bits [5:4] the width code and bit 0 the increment enable, and all three read back as written. Bits [2:0] of the address low word read as zero, because the buffer is 8-byte aligned.
- R3: Writing 1 to control bit 0 starts a transfer. Control bit 0 always reads 0, and control bit 1 reads the busy flag.
- R4: When direction bit 16 is 0 (memory to card), each beat is one memory read followed by one beat on the outbound stream that carries the read data. A memory request, with its address, is held unchanged until it is acknowledged, and an outbound beat is held until it is accepted. No request or stream activity occurs while the engine is idle.
- R5: When direction bit 16 is 1 (card to memory), each beat accepts one inbound stream word and then writes that word to memory (write strobe high), in arrival order.
- R6: Width code w gives a beat of 2^w bytes and is presented on the size output. The number of beats is the length input shifted right by w, taken at start, so trailing bytes short of a full beat are not moved. The first beat uses the programmed address, and each later beat adds 2^w when increment is 1 or repeats the same address when it is 0.
- R7: In the cycle after the last beat's handshake, done is high for one cycle and busy is low. A start with zero beats gives the same single done pulse and no memory or stream traffic.
- R8: A start written while the engine is busy is ignored, and the running transfer completes with its original beat count.
- R9: Clearing the run bit of the active channel (bit 8 for direction 0, bit 9 for direction 1) removes all requests and stream strobes at once. The engine is idle one cycle later, and done never fires.
- R10: A start is ignored while the channel for the programmed direction is held in reset. Clearing the other channel's run bit does not disturb a running transfer.
- R11: Writes to the mode, address or length after a start have no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| xfer_len | input | LEN_W | Transfer length in bytes, taken at start |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory beat address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| tx_valid | output | 1 | Outbound beat valid (toward card) |
| tx_data | output | DW | Outbound beat data |
| tx_ready | input | 1 | Outbound beat accepted |
| rx_valid | input | 1 | Inbound beat valid (from card) |
| rx_data | input | DW | Inbound beat data |
| rx_ready | output | 1 | Engine accepts inbound beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default parameters: a 64-bit address, 64-bit data and a 16-bit length. The high address word therefore reaches the memory port, and segments of a hundred beats or more are possible, which leaves room to abort in the middle of a transfer. A pseudo-random stall pattern on the acknowledge, ready and valid inputs exercises the hold-until-handshake paths in both directions. All four width codes, both address modes, lengths that are not a multiple of the beat size, and zero-beat starts are each run.

// File: rtl/sdh_dma_pkg.sv
package sdh_dma_pkg;

    // Register byte offsets
    localparam logic [7:0] OFF_MODE = 8'h00;
    localparam logic [7:0] OFF_CTRL = 8'h04;
    localparam logic [7:0] OFF_RST  = 8'h08;
    localparam logic [7:0] OFF_ALO  = 8'h0C;
    localparam logic [7:0] OFF_AHI  = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MRD,
        ST_TXO,
        ST_RXI,
        ST_MWR
    } dma_st_e;

    typedef struct packed {
        logic       dir;    // 0: memory to card, 1: card to memory
        logic [1:0] width;  // beat = 2^width bytes
        logic       inc;    // address advance per beat
    } dma_mode_t;

endpackage

// File: rtl/sdh_dma_regs.sv
module sdh_dma_regs
    import sdh_dma_pkg::*;
#(
    parameter int AW     = 64,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy_i,
    output logic [31:0]       reg_rdata,
    output logic              start_o,
    output dma_mode_t         mode_o,
    output logic [AW-1:0]     base_o,
    output logic [1:0]        ch_run_o
);

    localparam logic [REG_AW-1:0] A_MODE = REG_AW'(OFF_MODE);
    localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFF_CTRL);
    localparam logic [REG_AW-1:0] A_RST  = REG_AW'(OFF_RST);
    localparam logic [REG_AW-1:0] A_ALO  = REG_AW'(OFF_ALO);
    localparam logic [REG_AW-1:0] A_AHI  = REG_AW'(OFF_AHI);

    typedef struct packed {
        logic [1:0]  dir_fld;
        logic [1:0]  width;
        logic        inc;
        logic [1:0]  run;
        logic [31:0] alo;
        logic [31:0] ahi;
    } regs_t;

    regs_t q, d;
    logic [63:0] full_addr;

    always_comb begin
        d = q;
        if (reg_wr) begin
            unique case (reg_addr)
                A_MODE: begin
                    d.dir_fld = reg_wdata[17:16];
                    d.width   = reg_wdata[5:4];
                    d.inc     = reg_wdata[0];
                end
                A_RST:   d.run = reg_wdata[9:8];
                A_ALO:   d.alo = {reg_wdata[31:3], 3'b000};
                A_AHI:   d.ahi = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.run <= 2'b11;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_MODE:  reg_rdata = {14'b0, q.dir_fld, 10'b0, q.width, 3'b0, q.inc};
            A_CTRL:  reg_rdata = {30'b0, busy_i, 1'b0};
            A_RST:   reg_rdata = {22'b0, q.run, 8'b0};
            A_ALO:   reg_rdata = q.alo;
            A_AHI:   reg_rdata = q.ahi;
            default: reg_rdata = '0;
        endcase
    end

    assign full_addr    = {q.ahi, q.alo};
    assign base_o       = full_addr[AW-1:0];
    assign start_o      = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
    assign mode_o.dir   = q.dir_fld[0];
    assign mode_o.width = q.width;
    assign mode_o.inc   = q.inc;
    assign ch_run_o     = q.run;

endmodule

// File: rtl/sdh_dma_engine.sv
module sdh_dma_engine
    import sdh_dma_pkg::*;
#(
    parameter int AW    = 64,
    parameter int DW    = 64,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  dma_mode_t        mode_i,
    input  logic [AW-1:0]    base_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [1:0]       ch_run_i,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             tx_valid,
    output logic [DW-1:0]    tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    output logic             rx_ready,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [AW-1:0]    ONE_A = AW'(1);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    typedef struct packed {
        dma_st_e          st;
        logic             dir;
        logic [1:0]       width;
        logic             inc;
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] beats;
        logic [DW-1:0]    data;
        logic             done;
    } eng_t;

    eng_t q, d;
    logic run_act, live, fire;
    logic [AW-1:0] step;

    assign run_act = ch_run_i[q.dir];
    assign live    = (q.st != ST_IDLE) && run_act;
    assign step    = ONE_A << q.width;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        fire     = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        tx_valid = 1'b0;
        rx_ready = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i && ch_run_i[mode_i.dir]) begin
                    d.dir   = mode_i.dir;
                    d.width = mode_i.width;
                    d.inc   = mode_i.inc;
                    d.addr  = base_i;
                    d.beats = len_i >> mode_i.width;
                    if (d.beats == '0) d.done = 1'b1;
                    else               d.st   = mode_i.dir ? ST_RXI : ST_MRD;
                end
            end
            ST_MRD: begin
                mem_req = live;
                if (live && mem_ack) begin
                    d.data = mem_rdata;
                    d.st   = ST_TXO;
                end
            end
            ST_TXO: begin
                tx_valid = live;
                fire     = live && tx_ready;
            end
            ST_RXI: begin
                rx_ready = live;
                if (live && rx_valid) begin
                    d.data = rx_data;
                    d.st   = ST_MWR;
                end
            end
            ST_MWR: begin
                mem_req = live;
                mem_we  = live;
                fire    = live && mem_ack;
            end
            default: d.st = ST_IDLE;
        endcase

        // one beat finished: advance address and count
        if (fire) begin
            d.beats = q.beats - ONE_L;
            if (q.inc) d.addr = q.addr + step;
            if (q.beats == ONE_L) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end else begin
                d.st = q.dir ? ST_RXI : ST_MRD;
            end
        end

        // active channel held in reset: abandon the segment silently
        if (q.st != ST_IDLE && !run_act) begin
            d.st   = ST_IDLE;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr  = q.addr;
    assign mem_size  = q.width;
    assign mem_wdata = q.data;
    assign tx_data   = q.data;
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;

endmodule

// File: rtl/sdh_dma_top.sv
module sdh_dma_top
    import sdh_dma_pkg::*;
#(
    parameter int AW     = 64,
    parameter int DW     = 64,
    parameter int LEN_W  = 16,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    output logic              rx_ready,
    output logic              busy,
    output logic              done
);

    logic          start_w;
    dma_mode_t     mode_w;
    logic [AW-1:0] base_w;
    logic [1:0]    run_w;

    sdh_dma_regs #(.AW(AW), .REG_AW(REG_AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .busy_i   (busy),
        .reg_rdata(reg_rdata),
        .start_o  (start_w),
        .mode_o   (mode_w),
        .base_o   (base_w),
        .ch_run_o (run_w)
    );

    sdh_dma_engine #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .mode_i   (mode_w),
        .base_i   (base_w),
        .len_i    (xfer_len),
        .ch_run_i (run_w),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_size (mem_size),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .busy_o   (busy),
        .done_o   (done)
    );

endmodule

// File: rtl/sdh_dma_chk.sv
module sdh_dma_chk
    import sdh_dma_pkg::*;
#(
    parameter int AW     = 64,
    parameter int DW     = 64,
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [1:0]        run_bits,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_ack,
    input logic              tx_valid,
    input logic [DW-1:0]     tx_data,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              busy,
    input logic              done
);

    logic rst_wr, any_hs;
    assign rst_wr = reg_wr && (reg_addr == REG_AW'(OFF_RST));
    assign any_hs = (mem_req && mem_ack) || (tx_valid && tx_ready) || (rx_valid && rx_ready);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid && !rx_ready));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !rst_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !rst_wr) |=> (tx_valid && $stable(tx_data)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_wr && run_bits == 2'b00 && busy && !any_hs) |=> !done ##1 (!busy && !done));

endmodule

bind sdh_dma_top sdh_dma_chk #(.AW(AW), .DW(DW), .REG_AW(REG_AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .run_bits(reg_wdata[9:8]),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .mem_ack (mem_ack),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_ready(tx_ready),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .busy    (busy),
    .done    (done)
);

// File: tb/sdh_dma_top_tb_top.sv
`timescale 1ns/1ps
module sdh_dma_top_tb_top;

    localparam int AW = 64, DW = 64, LEN_W = 16, REG_AW = 8;
    localparam logic [7:0] A_MODE = 8'h00, A_CTRL = 8'h04, A_RST = 8'h08,
                           A_ALO = 8'h0C, A_AHI = 8'h10;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [LEN_W-1:0] xfer_len = '0;
    logic mem_req, mem_we, mem_ack = 0;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    logic [DW-1:0] mem_wdata, mem_rdata = '0, tx_data, rx_data = '0;
    logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, busy, done;

    always #4 clk = ~clk;

    sdh_dma_top #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .REG_AW(REG_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_len(xfer_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .busy(busy), .done(done));

    int nchk = 0, nerr = 0;
    int mem_ctr = 0, rx_ctr = 0;
    bit stall = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- responders ----------------
    always @(negedge clk) begin
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ack   = mem_req && (stall ? lfsr[0] : 1'b1);
        mem_rdata = {32'(mem_ctr) ^ 32'hC0DE0000, mem_addr[31:0] ^ 32'h5A5A5A5A};
        tx_ready  = stall ? lfsr[3] : 1'b1;
        rx_valid  = stall ? lfsr[6] : 1'b1;
        rx_data   = {32'h0DA70000 + 32'(rx_ctr), ~32'(rx_ctr)};
    end

    // ---------------- reference model ----------------
    bit m_busy = 0, m_done = 0, m_dir = 0, m_inc = 0;
    bit [1:0] m_run = 2'b11, m_w = 0;
    logic [63:0] m_addr = '0;
    int m_left = 0;
    logic [63:0] q_data[$];
    bit s_dir = 0, s_inc = 0;
    bit [1:0] s_w = 0;
    logic [31:0] s_alo = 0, s_ahi = 0;

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            bit nb, nd, beat;
            logic [63:0] e;
            nb = m_busy; nd = 0; beat = 0;
            chk(busy, m_busy, "R7 busy");
            chk(done, m_done, "R7 done");
            if (!m_busy)
                chk({mem_req, tx_valid, rx_ready}, 3'b000, "R4 idle quiet");
            if (m_busy && !m_run[m_dir]) begin
                chk({mem_req, tx_valid, rx_ready}, 3'b000, "R9 abort quiet");
                nb = 0;
            end else if (m_busy) begin
                if (mem_req && mem_ack) begin
                    chk(mem_addr, m_addr, "R6 addr");
                    chk(mem_size, m_w, "R6 size");
                    chk(mem_we, m_dir, "R5 we");
                    if (!m_dir) q_data.push_back(mem_rdata);
                    else begin
                        e = (q_data.size() > 0) ? q_data.pop_front() : 'x;
                        chk(mem_wdata, e, "R5 wdata");
                        beat = 1;
                    end
                    if (m_inc) m_addr = m_addr + (64'd1 << m_w);
                    mem_ctr++;
                end
                if (tx_valid && tx_ready) begin
                    chk(m_dir, 0, "R4 tx dir");
                    e = (q_data.size() > 0) ? q_data.pop_front() : 'x;
                    chk(tx_data, e, "R4 txdata");
                    beat = 1;
                end
                if (rx_valid && rx_ready) begin
                    q_data.push_back(rx_data);
                    rx_ctr++;
                end
                if (beat) begin
                    m_left--;
                    if (m_left == 0) begin nb = 0; nd = 1; end
                end
            end
            if (reg_wr && reg_addr == A_CTRL && reg_wdata[0] && !m_busy && m_run[s_dir]) begin
                m_dir = s_dir; m_w = s_w; m_inc = s_inc;
                m_addr = {s_ahi, s_alo};
                m_left = int'(xfer_len >> s_w);
                q_data.delete();
                if (m_left == 0) nd = 1; else nb = 1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    A_MODE: begin s_dir = reg_wdata[16]; s_w = reg_wdata[5:4]; s_inc = reg_wdata[0]; end
                    A_RST:  m_run = reg_wdata[9:8];
                    A_ALO:  s_alo = {reg_wdata[31:3], 3'b000};
                    A_AHI:  s_ahi = reg_wdata;
                    default: ;
                endcase
            end
            m_busy = nb; m_done = nd;
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata & mask, exp, tag);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input bit dir, input bit [1:0] w, input bit inc,
                         input logic [63:0] addr, input int len);
        wr(A_MODE, {14'b0, 1'b0, dir, 10'b0, w, 3'b0, inc});
        wr(A_ALO, addr[31:0]);
        wr(A_AHI, addr[63:32]);
        xfer_len = LEN_W'(len);
    endtask

    task automatic run(input bit dir, input bit [1:0] w, input bit inc,
                       input logic [63:0] addr, input int len);
        int c0;
        setup(dir, w, inc, addr, len);
        c0 = mem_ctr;
        wr(A_CTRL, 32'h1);
        wait_idle();
        chk(64'(mem_ctr - c0), 64'(len >> w), "R6 beat count");
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done}, 2'b00, "R1 busy/done");
        rd(A_MODE, 32'hFFFFFFFF, 32'h0, "R1 mode");
        rd(A_CTRL, 32'hFFFFFFFF, 32'h0, "R1 ctrl");
        rd(A_RST,  32'hFFFFFFFF, 32'h300, "R1 rst");
        rd(A_ALO,  32'hFFFFFFFF, 32'h0, "R1 alo");
        rd(A_AHI,  32'hFFFFFFFF, 32'h0, "R1 ahi");
        // R2 readback and alignment
        wr(A_MODE, 32'h0003_0031);
        rd(A_MODE, 32'hFFFFFFFF, 32'h0003_0031, "R2 mode");
        wr(A_ALO, 32'hFFFF_FFFF);
        rd(A_ALO, 32'hFFFFFFFF, 32'hFFFF_FFF8, "R2 alo");
        wr(A_AHI, 32'h1234_5678);
        rd(A_AHI, 32'hFFFFFFFF, 32'h1234_5678, "R2 ahi");

        // R4 / R6 memory to card, 64-bit beats, increment
        run(0, 2'd3, 1, 64'h0000_0001_0000_0100, 32);
        // R5 card to memory, 32-bit beats
        run(1, 2'd2, 1, 64'h8000_0000_0000_2000, 24);
        stall = 1;
        // stalled variants, fixed address, odd lengths
        run(0, 2'd0, 0, 64'h0000_0000_0000_3008, 5);
        run(1, 2'd1, 0, 64'h0000_0002_0000_4000, 9);
        run(0, 2'd2, 1, 64'h0000_0000_0000_5000, 14);
        run(1, 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFC0, 40);

        // R7 zero beats
        c0 = mem_ctr;
        setup(0, 2'd3, 1, 64'h6000, 7);
        wr(A_CTRL, 32'h1);
        wait_idle();
        chk(64'(mem_ctr), 64'(c0), "R7 zero beats no traffic");

        // R3 busy bit, R8 start while busy, R11 settings after start
        setup(1, 2'd3, 1, 64'h7000, 64);
        c0 = mem_ctr;
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, 32'h3, 32'h2, "R3 busy bit");
        wr(A_MODE, 32'h0000_0000);
        wr(A_ALO, 32'h0000_9000);
        xfer_len = 16'd2;
        wr(A_CTRL, 32'h1);
        wait_idle();
        chk(64'(mem_ctr - c0), 64'd8, "R8 start ignored while busy");
        rd(A_CTRL, 32'h3, 32'h0, "R3 idle ctrl");

        // R9 abort mid transfer
        setup(0, 2'd3, 1, 64'hA000, 800);
        wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        wr(A_RST, 32'h0);
        repeat (2) @(negedge clk);
        rd(A_CTRL, 32'h2, 32'h0, "R9 idle after abort");
        wr(A_RST, 32'h300);

        // R10 start ignored while channel 0 in reset
        wr(A_RST, 32'h200);
        setup(0, 2'd2, 1, 64'hB000, 16);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, 32'h2, 32'h0, "R10 start ignored in reset");
        wr(A_RST, 32'h300);
        // R10 clearing the other channel leaves transfer running
        setup(1, 2'd2, 1, 64'hC000, 40);
        c0 = mem_ctr;
        wr(A_CTRL, 32'h1);
        wr(A_RST, 32'h200);
        wait_idle();
        chk(64'(mem_ctr - c0), 64'd10, "R10 other channel no effect");
        wr(A_RST, 32'h300);

        // resume after abort: normal transfer still works
        run(0, 2'd1, 1, 64'hD000, 12);
        stall = 0;
        run(1, 2'd0, 1, 64'hE001, 6);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule